// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a synchronous host and an external asynchronous static RAM that holds 128K words of 16 bits. The host offers one word request at a time through a valid/ready handshake. Each request carries a write flag, a 17-bit word address, write data and a per-byte lane mask. The controller runs the RAM's active-low chip select, output enable, write enable and per-byte enables. It drives the write data and a separate drive-enable for the pad buffer, which lives outside the block. Read results come back with a one-cycle valid strobe.

All RAM timing is given in nanoseconds together with the clock period. Each value is rounded up to whole clock cycles when the block is elaborated, and the sequencer counts those cycles. A write always begins with a turnaround phase: chip select is low while both output enable and write enable are high. The RAM's outputs are therefore off before the controller starts to drive the bus. The controller stops driving on the same edge that raises write enable. Because of this ordering, the two sides never drive the bus at the same time.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, chip select, output enable, write enable and both byte enables are high, the bus drive-enable is low, `rsp_valid` is low and `req_ready` is high.
- R2: A read keeps chip select and output enable low and write enable high for RD = ceil(T_RC_NS/CLK_NS) cycles, starting in the cycle after acceptance. `mem_addr` equals the request address. `mem_be_n[0]` (data bits 7:0) is the inverse of lane-mask bit 0, and `mem_be_n[1]` (bits 15:8) is the inverse of bit 1.
- R3: `rsp_valid` is high for exactly one cycle, the cycle after the last read cycle. `rsp_rdata` then holds the bus value from that last read cycle, with each unselected lane forced to zero.
- R4: A write begins with TURN = max(1, ceil(T_OHZ_NS/CLK_NS)) cycles in which chip select is low, output enable and write enable are high, and the drive-enable is low.
- R5: After the turnaround, write enable stays low for PULSE = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)) cycles. Throughout those cycles `mem_dq_out` carries the write data.
- R6: The drive-enable is high only while write enable is low and output enable is high. It falls on the same edge that raises write enable.
- R7: A write keeps the block busy for max(ceil(T_WC_NS/CLK_NS), TURN+PULSE) cycles. Any cycles after the pulse are recovery cycles, with chip select low and output enable and write enable high.
- R8: `req_ready` is high only while no access is in progress. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. A request held during an access waits.
- R9: With lane mask 00, both byte enables stay high for the whole access. Such a write never enables the bus drivers, and such a read returns zero.
- R10: Between accesses, all RAM controls are high and the drive-enable is low.
- R11: The address and byte enables stay constant for every cycle in which chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_be_n | output | 2 | RAM byte enables, active low, bit 0 = lower lane |
| mem_dq_out | output | 16 | Data toward the pad buffer |
| mem_dq_drive | output | 1 | Pad buffer drive-enable |
| mem_dq_in | input | 16 | Data from the pad buffer |

## Verification
After acceptance, the read pins appear in the next cycle and stay for RD cycles, and `rsp_valid` follows one cycle after the last of them. A write holds TURN turnaround cycles, then PULSE cycles with write enable low, then recovery up to the write cycle total, and `req_ready` returns in the cycle after. The bench keeps a cycle-age counter for the current access and, at each falling edge, derives every expected pin level from that age and the cycle counts it computes from the nanosecond values. It then compares every output of the block in that same mid-cycle window. The bench instance lengthens the write cycle so that the recovery phase also occurs.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   localparam int PH_N    = 5;
   localparam int I_IDLE  = 0;
   localparam int I_READ  = 1;
   localparam int I_TURN  = 2;
   localparam int I_PULSE = 3;
   localparam int I_RECOV = 4;

   // one-hot so that every RAM control is a single flop bit
   typedef enum logic [PH_N-1:0] {
      PH_IDLE  = 5'b00001,
      PH_READ  = 5'b00010,
      PH_TURN  = 5'b00100,
      PH_PULSE = 5'b01000,
      PH_RECOV = 5'b10000
   } phase_e;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 16,
   parameter int LANES     = 2,
   parameter int RD_CYC    = 5,
   parameter int TURN_CYC  = 2,
   parameter int PULSE_CYC = 4,
   parameter int REC_CYC   = 0,
   parameter int CNT_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_lanes,
   output logic              req_ready,
   output phase_e            phase,
   output logic [ADDR_W-1:0] hold_addr,
   output logic [DATA_W-1:0] hold_wdata,
   output logic [LANES-1:0]  hold_lanes,
   output logic              last_read
);

   localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_CYC - 1);
   localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_REC   = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);
   localparam bit               HAS_REC  = (REC_CYC > 0);

   phase_e           ph_q, ph_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             accept;

   sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   assign accept = req_valid && (ph_q == PH_IDLE);

   always_comb begin
      ph_d     = ph_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (ph_q)
         PH_IDLE: if (req_valid) begin
            tmr_load = 1'b1;
            if (req_write) begin
               ph_d    = PH_TURN;
               tmr_val = LD_TURN;
            end else begin
               ph_d    = PH_READ;
               tmr_val = LD_RD;
            end
         end
         PH_READ: if (tmr_zero) ph_d = PH_IDLE;
         PH_TURN: if (tmr_zero) begin
            ph_d     = PH_PULSE;
            tmr_load = 1'b1;
            tmr_val  = LD_PULSE;
         end
         PH_PULSE: if (tmr_zero) begin
            if (HAS_REC) begin
               ph_d     = PH_RECOV;
               tmr_load = 1'b1;
               tmr_val  = LD_REC;
            end else begin
               ph_d = PH_IDLE;
            end
         end
         PH_RECOV: if (tmr_zero) ph_d = PH_IDLE;
         default:  ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         hold_addr  <= '0;
         hold_wdata <= '0;
         hold_lanes <= '0;
      end else begin
         ph_q <= ph_d;
         if (accept) begin
            hold_addr  <= req_addr;
            hold_wdata <= req_wdata;
            hold_lanes <= req_lanes;
         end
      end
   end

   assign req_ready = (ph_q == PH_IDLE);
   assign phase     = ph_q;
   assign last_read = (ph_q == PH_READ) && tmr_zero;

   // phase order of a write: turnaround always sits before the pulse
   assert_pulse_after_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_PULSE) && ($past(ph_q) != PH_PULSE) |-> $past(ph_q) == PH_TURN);

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  phase_e            phase,
   input  logic [ADDR_W-1:0] hold_addr,
   input  logic [DATA_W-1:0] hold_wdata,
   input  logic [LANES-1:0]  hold_lanes,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_drive
);

   logic [PH_N-1:0] ph_bits;

   assign ph_bits      = phase;
   assign mem_cs_n     = ph_bits[I_IDLE];
   assign mem_oe_n     = !ph_bits[I_READ];
   assign mem_we_n     = !ph_bits[I_PULSE];
   assign mem_addr     = hold_addr;
   assign mem_dq_out   = hold_wdata;
   assign mem_dq_drive = ph_bits[I_PULSE] && (|hold_lanes);

   for (genvar i = 0; i < LANES; i++) begin : g_be
      assign mem_be_n[i] = ph_bits[I_IDLE] || !hold_lanes[i];
   end

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [LANES-1:0]  lanes,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= cap_en;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)      rsp_rdata[i*8 +: 8] <= '0;
         else if (cap_en) rsp_rdata[i*8 +: 8] <= lanes[i] ? dq_in[i*8 +: 8] : 8'h00;
      end
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 16,
   parameter int CLK_NS   = 10,
   parameter int T_RC_NS  = 45,
   parameter int T_WC_NS  = 45,
   parameter int T_WP_NS  = 35,
   parameter int T_DW_NS  = 25,
   parameter int T_OHZ_NS = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_lanes,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_cs_n,
   output logic                mem_oe_n,
   output logic                mem_we_n,
   output logic [DATA_W/8-1:0] mem_be_n,
   output logic [DATA_W-1:0]   mem_dq_out,
   output logic                mem_dq_drive,
   input  logic [DATA_W-1:0]   mem_dq_in
);

   localparam int LANES     = DATA_W / 8;
   localparam int RD_CYC    = imax(1, ns_to_cyc(T_RC_NS, CLK_NS));
   localparam int TURN_CYC  = imax(1, ns_to_cyc(T_OHZ_NS, CLK_NS));
   localparam int PULSE_CYC = imax(1, imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)));
   localparam int WC_CYC    = ns_to_cyc(T_WC_NS, CLK_NS);
   localparam int REC_CYC   = (WC_CYC > TURN_CYC + PULSE_CYC) ? WC_CYC - TURN_CYC - PULSE_CYC : 0;
   localparam int CNT_MAX   = imax(imax(RD_CYC, PULSE_CYC), imax(TURN_CYC, REC_CYC));
   localparam int CNT_W     = imax(1, $clog2(CNT_MAX + 1));

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("sram_lane_ctrl: DATA_W must be a nonzero multiple of 8");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_lane_ctrl: CLK_NS must be positive");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram_lane_ctrl: ADDR_W must be positive");
   end

   phase_e              phase;
   logic [ADDR_W-1:0]   hold_addr;
   logic [DATA_W-1:0]   hold_wdata;
   logic [LANES-1:0]    hold_lanes;
   logic                last_read;

   sram_lane_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
      .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .PULSE_CYC(PULSE_CYC),
      .REC_CYC(REC_CYC), .CNT_W(CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_lanes  (req_lanes),
      .req_ready  (req_ready),
      .phase      (phase),
      .hold_addr  (hold_addr),
      .hold_wdata (hold_wdata),
      .hold_lanes (hold_lanes),
      .last_read  (last_read)
   );

   sram_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
      .phase        (phase),
      .hold_addr    (hold_addr),
      .hold_wdata   (hold_wdata),
      .hold_lanes   (hold_lanes),
      .mem_addr     (mem_addr),
      .mem_cs_n     (mem_cs_n),
      .mem_oe_n     (mem_oe_n),
      .mem_we_n     (mem_we_n),
      .mem_be_n     (mem_be_n),
      .mem_dq_out   (mem_dq_out),
      .mem_dq_drive (mem_dq_drive)
   );

   sram_read_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (last_read),
      .lanes     (hold_lanes),
      .dq_in     (mem_dq_in),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assert_bus_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_drive |-> (mem_oe_n && !mem_we_n));

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_dq_drive);

   assert_turn_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(mem_oe_n) && !$past(mem_cs_n)));

   assert_pins_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

   assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_rsp_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!$past(mem_oe_n) && mem_oe_n));

   assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && (&mem_be_n) && !mem_dq_drive));

   assert_no_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (&mem_be_n) |-> !mem_dq_drive);

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TRC  = 45;
   localparam int TWC  = 80;
   localparam int TWP  = 35;
   localparam int TDW  = 25;
   localparam int TOHZ = 20;

   localparam int B_RC    = (TRC + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_TURN  = (TOHZ + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_WP    = (TWP + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_DW    = (TDW + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_PULSE = (B_WP > B_DW) ? B_WP : B_DW;
   localparam int B_WC    = (TWC + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int B_WTOT  = (B_WC > B_TURN + B_PULSE) ? B_WC : B_TURN + B_PULSE;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_write;
   logic [16:0] req_addr;
   logic [15:0] req_wdata;
   logic [1:0]  req_lanes;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_cs_n, mem_oe_n, mem_we_n;
   logic [1:0]  mem_be_n;
   logic [15:0] mem_dq_out;
   logic        mem_dq_drive;
   logic [15:0] mem_dq_in;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_lane_ctrl #(
      .ADDR_W(17), .DATA_W(16), .CLK_NS(CLK_PERIOD),
      .T_RC_NS(TRC), .T_WC_NS(TWC), .T_WP_NS(TWP), .T_DW_NS(TDW), .T_OHZ_NS(TOHZ)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
      .mem_dq_in(mem_dq_in)
   );

   // ---------------- behavioural RAM on the pins ----------------
   logic [15:0] ram [int];

   function automatic logic [15:0] ram_get(input logic [16:0] a);
      return ram.exists(int'(a)) ? ram[int'(a)] : 16'h0000;
   endfunction

   always_comb begin
      logic [15:0] rd;
      rd = ram_get(mem_addr);
      for (int i = 0; i < 2; i++)
         mem_dq_in[i*8 +: 8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_be_n[i]) ? rd[i*8 +: 8] : 8'h5A;
   end

   always @(posedge clk) begin
      if (!mem_cs_n && !mem_we_n && mem_dq_drive) begin
         logic [15:0] cur;
         cur = ram_get(mem_addr);
         for (int i = 0; i < 2; i++)
            if (!mem_be_n[i]) cur[i*8 +: 8] = mem_dq_out[i*8 +: 8];
         ram[int'(mem_addr)] = cur;
      end
   end

   // ---------------- reference model ----------------
   int          compared = 0;
   int          mismatched = 0;
   int          age = 0;
   logic        m_wr;
   logic [16:0] m_addr;
   logic [15:0] m_data;
   logic [1:0]  m_lanes;
   logic        exp_rsp = 1'b0;
   logic [15:0] exp_rdata = '0;
   logic        exp_zero_lanes = 1'b0;
   logic [15:0] shadow [int];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic check_cycle();
      logic e_cs, e_oe, e_we, e_drv;
      logic [1:0] e_be;
      string t;
      e_cs = 1; e_oe = 1; e_we = 1; e_drv = 0; e_be = 2'b11; t = "R10";
      if (age > 0) begin
         e_cs = 0;
         e_be = ~m_lanes;
         if (!m_wr) begin e_oe = 0; t = "R2"; end
         else if (age <= B_TURN) t = "R4";
         else if (age <= B_TURN + B_PULSE) begin e_we = 0; e_drv = (m_lanes != 0); t = "R5"; end
         else t = "R7";
         if (m_lanes == 2'b00) t = "R9";
      end
      chk({t, " cs_n"}, 32'(mem_cs_n), 32'(e_cs));
      chk({t, " oe_n"}, 32'(mem_oe_n), 32'(e_oe));
      chk({t, " we_n"}, 32'(mem_we_n), 32'(e_we));
      chk({t, " be_n"}, 32'(mem_be_n), 32'(e_be));
      chk("R6 dq_drive", 32'(mem_dq_drive), 32'(e_drv));
      if (age > 0) chk("R11 addr", 32'(mem_addr), 32'(m_addr));
      if (e_drv)   chk("R5 dq_out", 32'(mem_dq_out), 32'(m_data));
      chk("R8 ready", 32'(req_ready), 32'(age == 0));
      chk("R3 rsp_valid", 32'(rsp_valid), 32'(exp_rsp));
      if (exp_rsp) chk(exp_zero_lanes ? "R9 rdata" : "R3 rdata", 32'(rsp_rdata), 32'(exp_rdata));
   endtask

   task automatic advance(input logic acc, input logic w, input logic [16:0] a,
                          input logic [15:0] d, input logic [1:0] m);
      logic nrsp;
      nrsp = 1'b0;
      if (age == 0) begin
         if (acc) begin
            age = 1; m_wr = w; m_addr = a; m_data = d; m_lanes = m;
            if (w) begin
               logic [15:0] old;
               old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
               if (m[0]) old[7:0]  = d[7:0];
               if (m[1]) old[15:8] = d[15:8];
               shadow[int'(a)] = old;
            end
         end
      end else if (age == (m_wr ? B_WTOT : B_RC)) begin
         age = 0;
         if (!m_wr) begin
            logic [15:0] v;
            v = shadow.exists(int'(m_addr)) ? shadow[int'(m_addr)] : 16'h0000;
            nrsp = 1'b1;
            exp_rdata = {m_lanes[1] ? v[15:8] : 8'h00, m_lanes[0] ? v[7:0] : 8'h00};
            exp_zero_lanes = (m_lanes == 2'b00);
         end
      end else begin
         age++;
      end
      exp_rsp = nrsp;
   endtask

   task automatic cycle(input logic v, input logic w, input logic [16:0] a,
                        input logic [15:0] d, input logic [1:0] m, output logic acc);
      @(negedge clk);
      check_cycle();
      req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_lanes = m;
      acc = v && (age == 0);
      advance(acc, w, a, d, m);
   endtask

   task automatic issue(input logic w, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
      logic acc;
      do cycle(1'b1, w, a, d, m, acc); while (!acc);
   endtask

   task automatic idle(input int n);
      logic acc;
      for (int i = 0; i < n; i++) cycle(1'b0, 1'b1, 17'h1FFFF, 16'hFFFF, 2'b11, acc);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_lanes = '0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (i > 0) begin
            chk("R1 cs_n", 32'(mem_cs_n), 32'd1);
            chk("R1 oe_n", 32'(mem_oe_n), 32'd1);
            chk("R1 we_n", 32'(mem_we_n), 32'd1);
            chk("R1 be_n", 32'(mem_be_n), 32'd3);
            chk("R1 dq_drive", 32'(mem_dq_drive), 32'd0);
            chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
            chk("R1 ready", 32'(req_ready), 32'd1);
         end
      end
      rst_n = 1'b1;
      idle(2);
      issue(1'b1, 17'h00010, 16'h1234, 2'b11);   // full write (R5, R7)
      idle(1);
      issue(1'b1, 17'h10010, 16'hBEEF, 2'b11);   // high address
      issue(1'b0, 17'h00010, 16'h0000, 2'b11);   // full read back to back (R8)
      issue(1'b0, 17'h10010, 16'h0000, 2'b01);   // lower lane read
      issue(1'b1, 17'h00010, 16'hAB99, 2'b10);   // upper lane write
      issue(1'b0, 17'h00010, 16'h0000, 2'b10);   // upper lane read
      issue(1'b0, 17'h00010, 16'h0000, 2'b11);
      issue(1'b1, 17'h00010, 16'hFFFF, 2'b00);   // R9 no-lane write
      issue(1'b0, 17'h00010, 16'h0000, 2'b11);
      issue(1'b0, 17'h00010, 16'h0000, 2'b00);   // R9 no-lane read
      issue(1'b1, 17'h00022, 16'h00C3, 2'b01);   // lower lane write
      idle(3);
      issue(1'b0, 17'h00022, 16'h0000, 2'b11);
      issue(1'b0, 17'h1FFFF, 16'h0000, 2'b11);   // unwritten word
      idle(12);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule